// File: doc/BRIEF.md
# SPI Slave CRC Checker

This block sits beside the shift logic of an SPI slave and keeps a running CRC over every bit that arrives on the data input while the slave is selected. The polynomial is programmable and is 0x0007 after reset. The frame length picks either a half-width CRC (8 bits at the default width) or a full-width CRC (16 bits). Bits are folded in MSB first. The serial clock, select and data inputs are brought into the system clock domain by short synchronisers. The accumulator advances on the data-sampling edge that the clock polarity and phase settings select. When the TI frame format is selected, that edge is fixed to the falling edge.

Software ends a checked transfer by raising the CRC-next request during the last data frame and then dropping it. The frame that follows is taken as the received CRC word. This word is not folded into the accumulator. It is compared with the accumulator value built from the data frames. A mismatch sets a sticky CRC error flag. The flag is also set if the select line goes high before the whole CRC word has arrived.

The accumulator keeps running whenever CRC is enabled, whether the SPI enable is set or not. It is cleared only by a fresh rise of the CRC enable. The error interrupt is a level output: the OR of the CRC error flag and three error flags supplied from elsewhere, gated by one shared enable.

Top module: `spi_crc_slave`

## Requirements
- R1: After reset, crcValue is 0, crcErr is 0 and errIrq is 0, and the polynomial register holds 0x0007.
- R2: Each sampled bit b updates the accumulator c to ((c << 1) XOR (f ? poly : 0)), masked to the frame width, where f is b XOR the top bit of c. The top bit is bit 7 when frame16 = 0 and bit 15 when frame16 = 1. Bits arrive MSB first.
- R3: The accumulator advances on every sampled bit while crcEn = 1 and nss = 0, whatever the value of spiEn. While crcEn = 0 it holds its value.
- R4: The accumulator returns to 0 only when crcEn goes from 0 to 1. Toggling spiEn or nss leaves it unchanged.
- R5: A bit is sampled on the rising SCK edge when cpol equals cpha, and on the falling edge otherwise. When tiMode = 1, the falling edge is used whatever cpol and cpha say.
- R6: crcNext = 1 while crcEn = 1 and spiEn = 1 arms the CRC phase. Its later release at a frame boundary makes the next frame the CRC word. This word is not folded into crcValue. crcNext has no effect while spiEn = 0.
- R7: At the end of the CRC word, crcErr is set if the word differs from crcValue, and it stays 0 if the two are equal.
- R8: If nss goes high during the CRC phase, crcErr is set.
- R9: crcErr stays set until a pulse on crcErrClr clears it.
- R10: errIrq = errIe AND (crcErr OR modeFault OR overrun OR tiFrameErr), as a level.
- R11: A pulse on polyWe loads polyWdata as the polynomial used by later updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| nss | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data into the slave |
| crcEn | input | 1 | CRC enable; its rising edge clears the accumulator |
| spiEn | input | 1 | Peripheral enable |
| crcNext | input | 1 | CRC-next request; its release starts the CRC phase |
| tiMode | input | 1 | TI frame format select |
| cpol | input | 1 | Clock polarity setting |
| cpha | input | 1 | Clock phase setting |
| frame16 | input | 1 | 1 selects a 16-bit frame and CRC, 0 selects 8-bit |
| polyWe | input | 1 | Polynomial write strobe |
| polyWdata | input | CRC_W | Polynomial write data |
| crcErrClr | input | 1 | Clears the CRC error flag |
| errIe | input | 1 | Shared error interrupt enable |
| modeFault | input | 1 | Mode fault flag |
| overrun | input | 1 | Overrun flag |
| tiFrameErr | input | 1 | TI frame format error flag |
| crcValue | output | CRC_W | Accumulated CRC |
| crcErr | output | 1 | Sticky CRC error flag |
| errIrq | output | 1 | Combined error interrupt, level |

## Verification
The bench uses the default CRC_W = 16 and two synchroniser stages. With that width it can run both the 8-bit and the 16-bit CRC, with 8-bit and 16-bit polynomials, under all four clock polarity and phase settings and under the TI format. The table of vectors runs those combinations against a bit-serial model of R2. The directed tests cover the CRC phase with both word widths and both outcomes, a select line that rises in the middle of the CRC word, and an accumulator that runs with the peripheral disabled.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,
    PH_ARMED = 2'd1,
    PH_CRC   = 2'd2
  } phase_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clearAcc;
    logic shiftAcc;
    logic clearRx;
    logic shiftRx;
    logic bitVal;
  } dpCtl_t;

endpackage

// File: rtl/spi_crc_sync.sv
module spi_crc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= INIT;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{INIT}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_crc_dp.sv
module spi_crc_dp
  import spi_crc_pkg::*;
#(
  parameter int               CRC_W      = 16,
  parameter logic [CRC_W-1:0] POLY_RESET = CRC_W'(7)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             frame16,
  input  logic             polyWe,
  input  logic [CRC_W-1:0] polyWdata,
  output logic [CRC_W-1:0] acc,
  output logic             wordBad
);

  localparam int SHORT_W = CRC_W / 2;
  localparam logic [CRC_W-1:0] SHORT_MASK =
    {{(CRC_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] rxShift;
  logic [CRC_W-1:0] widthMask;
  logic [CRC_W-1:0] accNext;
  logic [CRC_W-1:0] rxNext;
  logic             topBit;
  logic             feedback;

  assign widthMask = frame16 ? {CRC_W{1'b1}} : SHORT_MASK;
  assign topBit    = frame16 ? acc[CRC_W-1] : acc[SHORT_W-1];
  assign feedback  = topBit ^ ctl.bitVal;
  assign accNext   = ({acc[CRC_W-2:0], 1'b0} ^ (feedback ? poly : '0)) & widthMask;
  assign rxNext    = {rxShift[CRC_W-2:0], ctl.bitVal} & widthMask;
  assign wordBad   = rxNext != acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       poly <= POLY_RESET;
    else if (polyWe) poly <= polyWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             acc <= '0;
    else if (ctl.clearAcc) acc <= '0;
    else if (ctl.shiftAcc) acc <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (ctl.clearRx) rxShift <= '0;
    else if (ctl.shiftRx) rxShift <= rxNext;
  end

  // R4: only a clear or a shift strobe may move the accumulator
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clearAcc && !ctl.shiftAcc) |=> $stable(acc));

  // R4: a clear strobe leaves the accumulator at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAcc |=> (acc == '0));

endmodule

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl
  import spi_crc_pkg::*;
#(
  parameter int CRC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sck,
  input  logic   nss,
  input  logic   mosi,
  input  logic   crcEn,
  input  logic   spiEn,
  input  logic   crcNext,
  input  logic   tiMode,
  input  logic   cpol,
  input  logic   cpha,
  input  logic   frame16,
  input  logic   wordBad,
  input  logic   crcErrClr,
  output dpCtl_t dpCtl,
  output phase_e phase,
  output logic   crcErr
);

  localparam int SHORT_W = CRC_W / 2;
  localparam int CNT_W   = $clog2(CRC_W + 1);

  logic sckS, nssS, mosiS;
  logic sckPrev, crcEnPrev;
  logic effPol, effPha, sampleEdge, bitTick, enRise, lastBit, setErr;
  logic [CNT_W-1:0] bitCnt, frameLast;
  phase_e phaseNext;

  spi_crc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_syncSck
    (.clk(clk), .rstN(rstN), .din(sck),  .dout(sckS));
  spi_crc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_syncNss
    (.clk(clk), .rstN(rstN), .din(nss),  .dout(nssS));
  spi_crc_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_syncMosi
    (.clk(clk), .rstN(rstN), .din(mosi), .dout(mosiS));

  // TI format forces idle-low clock with second-edge sampling
  assign effPol     = tiMode ? 1'b0 : cpol;
  assign effPha     = tiMode ? 1'b1 : cpha;
  assign sampleEdge = (effPol == effPha) ? (sckS & ~sckPrev) : (~sckS & sckPrev);
  assign bitTick    = sampleEdge & ~nssS;
  assign enRise     = crcEn & ~crcEnPrev;
  assign frameLast  = frame16 ? CNT_W'(CRC_W - 1) : CNT_W'(SHORT_W - 1);
  assign lastBit    = bitCnt == frameLast;

  always_comb begin
    dpCtl.clearAcc = enRise;
    dpCtl.shiftAcc = bitTick & crcEn & (phase != PH_CRC) & ~enRise;
    dpCtl.clearRx  = (phase == PH_ARMED) & ~crcNext;
    dpCtl.shiftRx  = bitTick & (phase == PH_CRC);
    dpCtl.bitVal   = mosiS;
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_DATA:  if (spiEn && crcNext) phaseNext = PH_ARMED;
      PH_ARMED: if (!crcNext) phaseNext = PH_CRC;
      PH_CRC:   if (nssS || (bitTick && lastBit)) phaseNext = PH_DATA;
      default:  phaseNext = PH_DATA;
    endcase
    if (!crcEn || enRise) phaseNext = PH_DATA;
  end

  assign setErr = (phase == PH_CRC) & crcEn & (nssS | (bitTick & lastBit & wordBad));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      crcEnPrev <= 1'b0;
      phase     <= PH_DATA;
      bitCnt    <= '0;
      crcErr    <= 1'b0;
    end else begin
      sckPrev   <= sckS;
      crcEnPrev <= crcEn;
      phase     <= phaseNext;
      if (nssS)         bitCnt <= '0;
      else if (bitTick) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      if (setErr)         crcErr <= 1'b1;
      else if (crcErrClr) crcErr <= 1'b0;
    end
  end

  // R8: select released in the CRC phase flags a corrupted CRC
  a_r8_nss_abort: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CRC && nssS && crcEn) |=> crcErr);

  // R9: the error flag holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !crcErrClr) |=> crcErr);

  // R6: releasing the request while armed opens the CRC phase
  a_r6_phase_entry: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ARMED && !crcNext && crcEn && crcEnPrev) |=> (phase == PH_CRC));

endmodule

// File: rtl/spi_crc_slave.sv
module spi_crc_slave
  import spi_crc_pkg::*;
#(
  parameter int               CRC_W       = 16,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CRC_W-1:0] POLY_RESET  = CRC_W'(7)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             nss,
  input  logic             mosi,
  input  logic             crcEn,
  input  logic             spiEn,
  input  logic             crcNext,
  input  logic             tiMode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             frame16,
  input  logic             polyWe,
  input  logic [CRC_W-1:0] polyWdata,
  input  logic             crcErrClr,
  input  logic             errIe,
  input  logic             modeFault,
  input  logic             overrun,
  input  logic             tiFrameErr,
  output logic [CRC_W-1:0] crcValue,
  output logic             crcErr,
  output logic             errIrq
);

  dpCtl_t dpCtl;
  phase_e phase;
  logic   wordBad;

  spi_crc_ctrl #(.CRC_W(CRC_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .nss(nss), .mosi(mosi),
    .crcEn(crcEn), .spiEn(spiEn), .crcNext(crcNext), .tiMode(tiMode),
    .cpol(cpol), .cpha(cpha), .frame16(frame16), .wordBad(wordBad),
    .crcErrClr(crcErrClr), .dpCtl(dpCtl), .phase(phase), .crcErr(crcErr)
  );

  spi_crc_dp #(.CRC_W(CRC_W), .POLY_RESET(POLY_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .frame16(frame16),
    .polyWe(polyWe), .polyWdata(polyWdata), .acc(crcValue), .wordBad(wordBad)
  );

  assign errIrq = errIe & (crcErr | modeFault | overrun | tiFrameErr);

  // R6: the received CRC word never reaches the accumulator
  a_r6_acc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CRC && crcEn) |=> $stable(crcValue));

endmodule

// File: tb/spi_crc_slave_tb.sv
module spi_crc_slave_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, nss = 1'b1, mosi = 1'b0;
  logic crcEn = 1'b0, spiEn = 1'b0, crcNext = 1'b0;
  logic tiMode = 1'b0, cpol = 1'b0, cpha = 1'b0, frame16 = 1'b0;
  logic polyWe = 1'b0;
  logic [15:0] polyWdata = 16'h0;
  logic crcErrClr = 1'b0, errIe = 1'b0;
  logic modeFault = 1'b0, overrun = 1'b0, tiFrameErr = 1'b0;
  logic [15:0] crcValue;
  logic crcErr, errIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_crc_slave u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .nss(nss), .mosi(mosi),
    .crcEn(crcEn), .spiEn(spiEn), .crcNext(crcNext), .tiMode(tiMode),
    .cpol(cpol), .cpha(cpha), .frame16(frame16), .polyWe(polyWe),
    .polyWdata(polyWdata), .crcErrClr(crcErrClr), .errIe(errIe),
    .modeFault(modeFault), .overrun(overrun), .tiFrameErr(tiFrameErr),
    .crcValue(crcValue), .crcErr(crcErr), .errIrq(errIrq)
  );

  // {frame16, cpol, cpha, tiMode, poly, data}
  localparam logic [35:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0007, 16'h00A5},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'h0007, 16'h003C},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h0031, 16'h00F0},
    {1'b0, 1'b1, 1'b1, 1'b0, 16'h001D, 16'h0055},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'h0007, 16'h0096},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h1021, 16'h1234},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'h8005, 16'hBEEF},
    {1'b1, 1'b1, 1'b1, 1'b1, 16'h1021, 16'h0F0F}
  };

  function automatic logic [15:0] refCrc(logic [15:0] init, logic [15:0] poly,
                                         logic [15:0] data, bit wide);
    logic [15:0] c, m;
    logic top, fb;
    c = init;
    m = wide ? 16'hFFFF : 16'h00FF;
    for (int i = (wide ? 15 : 7); i >= 0; i--) begin
      top = wide ? c[15] : c[7];
      fb  = top ^ data[i];
      c   = ((c << 1) ^ (fb ? poly : 16'h0)) & m;
    end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic sendBits(logic [15:0] data, int n, bit ep, bit eh);
    for (int i = n - 1; i >= 0; i--) begin
      if (!eh) begin
        mosi = data[i];
        waitClk(8);
        sck = ~ep;
        waitClk(8);
        sck = ep;
      end else begin
        sck = ~ep;
        waitClk(4);
        mosi = data[i];
        waitClk(4);
        sck = ep;
        waitClk(8);
      end
    end
    waitClk(4);
  endtask

  task automatic frame(logic [15:0] data, int n, bit ep, bit eh);
    sck = ep;
    waitClk(4);
    nss = 1'b0;
    waitClk(4);
    sendBits(data, n, ep, eh);
    waitClk(4);
    nss = 1'b1;
    waitClk(8);
  endtask

  task automatic clearCrc();
    crcEn = 1'b0;
    waitClk(4);
    crcEn = 1'b1;
    waitClk(4);
  endtask

  task automatic loadPoly(logic [15:0] p);
    polyWdata = p;
    polyWe = 1'b1;
    waitClk(1);
    polyWe = 1'b0;
    waitClk(1);
  endtask

  // one data word, then the CRC word, in a single selection
  task automatic crcTransfer(logic [15:0] data, logic [15:0] word, int n);
    sck = 1'b0;
    crcNext = 1'b1;
    waitClk(4);
    nss = 1'b0;
    waitClk(4);
    sendBits(data, n, 1'b0, 1'b0);
    waitClk(4);
    crcNext = 1'b0;
    waitClk(4);
    sendBits(word, n, 1'b0, 1'b0);
    waitClk(4);
    nss = 1'b1;
    waitClk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [15:0] exp, held;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset state
    check("R1 crcValue", 32'(crcValue), 32'h0);
    check("R1 crcErr", 32'(crcErr), 32'h0);
    check("R1 errIrq", 32'(errIrq), 32'h0);

    // R1 R2: default polynomial 0x07, hand values
    crcEn = 1'b1;
    waitClk(4);
    frame(16'h0001, 8, 1'b0, 1'b0);
    check("R1 R2 default poly byte 01", 32'(crcValue), 32'h07);
    clearCrc();
    frame(16'h0080, 8, 1'b0, 1'b0);
    check("R2 byte 80", 32'(crcValue), 32'h89);

    // R2 R5 R11: vector table over modes, widths and polynomials
    for (int v = 0; v < 8; v++) begin
      bit f16, cp, ch, ti, ep, eh;
      logic [15:0] p, d;
      {f16, cp, ch, ti, p, d} = VECS[v];
      ep = ti ? 1'b0 : cp;
      eh = ti ? 1'b1 : ch;
      frame16 = f16; cpol = cp; cpha = ch; tiMode = ti;
      loadPoly(p);
      clearCrc();
      frame(d, f16 ? 16 : 8, ep, eh);
      check($sformatf("R2 R5 R11 vector %0d", v), 32'(crcValue),
            32'(refCrc(16'h0, p, d, f16)));
    end
    frame16 = 1'b0; cpol = 1'b0; cpha = 1'b0; tiMode = 1'b0;
    loadPoly(16'h0007);

    // R3: runs with spiEn = 0, holds with crcEn = 0
    spiEn = 1'b0;
    clearCrc();
    frame(16'h00C3, 8, 1'b0, 1'b0);
    exp = refCrc(16'h0, 16'h0007, 16'h00C3, 1'b0);
    check("R3 update with spiEn low", 32'(crcValue), 32'(exp));
    crcEn = 1'b0;
    waitClk(4);
    frame(16'h005A, 8, 1'b0, 1'b0);
    check("R3 hold with crcEn low", 32'(crcValue), 32'(exp));

    // R4: spiEn and nss toggles do not clear, crcEn rise does
    spiEn = 1'b1; waitClk(4); spiEn = 1'b0; waitClk(4);
    nss = 1'b0; waitClk(6); nss = 1'b1; waitClk(6);
    check("R4 no clear on spiEn or nss", 32'(crcValue), 32'(exp));
    crcEn = 1'b1;
    waitClk(4);
    check("R4 clear on crcEn rise", 32'(crcValue), 32'h0);

    // R6 R7: 8-bit CRC phase with a matching word
    spiEn = 1'b1;
    exp = refCrc(16'h0, 16'h0007, 16'h0042, 1'b0);
    crcTransfer(16'h0042, exp, 8);
    check("R7 match leaves crcErr clear", 32'(crcErr), 32'h0);
    check("R6 CRC word not folded", 32'(crcValue), 32'(exp));

    // R7 R10: wrong word sets the flag, interrupt gated by errIe
    clearCrc();
    exp = refCrc(16'h0, 16'h0007, 16'h0011, 1'b0);
    crcTransfer(16'h0011, exp ^ 16'h0001, 8);
    check("R7 mismatch sets crcErr", 32'(crcErr), 32'h1);
    check("R10 irq masked when errIe low", 32'(errIrq), 32'h0);
    errIe = 1'b1;
    waitClk(1);
    check("R10 irq from crcErr", 32'(errIrq), 32'h1);

    // R9: sticky through further traffic, cleared by pulse
    frame(16'h0033, 8, 1'b0, 1'b0);
    check("R9 crcErr sticky", 32'(crcErr), 32'h1);
    crcErrClr = 1'b1; waitClk(1); crcErrClr = 1'b0; waitClk(1);
    check("R9 crcErr cleared", 32'(crcErr), 32'h0);
    check("R10 irq drops with flag", 32'(errIrq), 32'h0);

    // R8: nss released during the CRC word
    clearCrc();
    sck = 1'b0; crcNext = 1'b1; waitClk(4);
    nss = 1'b0; waitClk(4);
    sendBits(16'h00AA, 8, 1'b0, 1'b0);
    crcNext = 1'b0; waitClk(4);
    sendBits(16'h0005, 3, 1'b0, 1'b0);
    nss = 1'b1;
    waitClk(8);
    check("R8 nss abort sets crcErr", 32'(crcErr), 32'h1);
    crcErrClr = 1'b1; waitClk(1); crcErrClr = 1'b0; waitClk(1);

    // R6 R7: 16-bit CRC phase with a matching word
    frame16 = 1'b1;
    loadPoly(16'h1021);
    clearCrc();
    exp = refCrc(16'h0, 16'h1021, 16'hA55A, 1'b1);
    crcTransfer(16'hA55A, exp, 16);
    check("R7 16-bit match", 32'(crcErr), 32'h0);
    check("R6 16-bit CRC word not folded", 32'(crcValue), 32'(exp));

    // R6: crcNext ignored while spiEn = 0, the frame is data
    spiEn = 1'b0;
    held = crcValue;
    crcTransfer(16'h1111, 16'h2222, 16);
    exp = refCrc(refCrc(held, 16'h1021, 16'h1111, 1'b1), 16'h1021, 16'h2222, 1'b1);
    check("R6 no CRC phase when spiEn low", 32'(crcErr), 32'h0);
    check("R6 both frames folded", 32'(crcValue), 32'(exp));

    // R10: each external flag, with and without the enable
    errIe = 1'b0;
    modeFault = 1'b1; waitClk(1);
    check("R10 modeFault masked", 32'(errIrq), 32'h0);
    errIe = 1'b1; waitClk(1);
    check("R10 modeFault", 32'(errIrq), 32'h1);
    modeFault = 1'b0; overrun = 1'b1; waitClk(1);
    check("R10 overrun", 32'(errIrq), 32'h1);
    overrun = 1'b0; tiFrameErr = 1'b1; waitClk(1);
    check("R10 tiFrameErr", 32'(errIrq), 32'h1);
    tiFrameErr = 1'b0; waitClk(1);
    check("R10 all clear", 32'(errIrq), 32'h0);

    done = 1'b1;
    finishRun();
  end

endmodule